// File: doc/BRIEF.md
# Lockable Clock-Buffer Control Register File

This block is the byte-wide configuration store behind a twenty-output differential clock buffer. A serial management engine, outside the block, turns bus transactions into an 8-bit offset, a data byte and a one-cycle write strobe. The block answers with the addressed byte on a combinational read port. The stored fields drive the buffer directly: per-output enables, side-band disable masks, two slew-select bits per output, four slew option slots, a global amplitude code, input coupling and termination settings, and a few housekeeping controls for the bus engine.

Two write locks protect the configuration. The first is a one-way latch that only a power-on reset releases. The second is a toggle that software can set and later release. Either lock freezes every control field, while the lock register pair itself stays writable. A loss-of-signal input from the clock detector sets a sticky event flag, and software clears that flag by writing 1. Status inputs (output-enable pin states, the side-band enable pin, per-output side-band state and the live loss signal) are reflected at read-only offsets.

Top module: `clkbuf_ctrl_regs`

## Requirements
- R1: After reset, all twenty output enables and slew MSB bits are 1; side-band masks, slew LSB bits, slew option slots, both locks and the loss flag are 0; the amplitude code is 6; the byte count is 7; the auto-disable enable (offset 0x04 bit 4), the keep-config bit (0x15 bit 3) and the data-timeout enable (0x15 bit 2) are 1.
- R2: Offset 0x05 reads the revision code in bits 7:4 and vendor code 0xA in bits 3:0. Offset 0x06 reads device code 0xC9. Writes to either offset have no effect.
- R3: Control fields are readable and writable at fixed positions, with bit n mapping to output n within each group. Enables: 0x01 (outputs 0-7), 0x02 (8-15), 0x00 bits 6:3 (16-19). Masks: 0x08, 0x09, 0x0A bits 3:0. Slew MSB: 0x0B, 0x0C, 0x0D bits 3:0. Slew LSB: 0x62, 0x63, 0x64 bits 3:0. Slew slots: 0x5B (slot 1 in bits 3:0, slot 2 in bits 7:4) and 0x5C (slot 3, slot 4). Amplitude: 0x14 bits 7:4. Byte count: 0x07 bits 4:0. Input coupling and termination: 0x15 bits 7 and 6.
- R4: Reserved bits of mapped offsets always read 0, whatever was written.
- R5: Only offsets 0x00-0x0D, 0x14, 0x15, 0x21-0x23, 0x26, 0x27, 0x5B, 0x5C and 0x62-0x64 exist. A write anywhere else changes nothing, and a read there returns 0.
- R6: Writing 1 to bit 0 of 0x26 sets the permanent lock, which reads back in that bit. Writing 0 never clears it; only reset does.
- R7: Writing 1 to bit 0 of 0x27 sets the clearable lock when it is clear and clears it when it is set. Writing 0 to that bit leaves it unchanged.
- R8: While either lock is set, writes to every offset other than 0x26 and 0x27 are ignored. Writes to 0x26 and 0x27 are still accepted.
- R9: The loss flag (0x27 bit 1) becomes 1 on the edge after any cycle with loss_in high and stays 1. Writing 1 to it clears it, unless loss_in is high in that same cycle, in which case the flag stays 1.
- R10: Offset 0x03 reads oe_pin_stat. Offset 0x04 bit 0 reads sb_en_stat. Offset 0x15 bit 0 reads the inverse of loss_in. Offsets 0x21, 0x22 and 0x23 bits 3:0 read sb_state for outputs 0-7, 8-15 and 16-19.
- R11: A write updates storage at the clock edge where wr_en is sampled high. Read data follows addr combinationally, so during the write cycle it still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rdata | output | 8 | Read data for addr |
| loss_in | input | 1 | Loss-of-signal indication from the detector, high on loss |
| oe_pin_stat | input | 8 | Sampled output-enable pin states for readback |
| sb_en_stat | input | 1 | Side-band enable pin state for readback |
| sb_state | input | 20 | Per-output side-band disable state for readback |
| out_en | output | 20 | Per-output enables |
| sb_mask | output | 20 | Per-output side-band disable masks |
| slew_msb | output | 20 | Per-output slew select, upper bit |
| slew_lsb | output | 20 | Per-output slew select, lower bit |
| slew_opt | output | 16 | Four 4-bit slew slots, slot 1 in bits 3:0 |
| amp_code | output | 4 | Global output amplitude code |
| blk_count | output | 5 | Block-read byte count for the bus engine |
| auto_dis_en | output | 1 | Enable automatic output disable on loss |
| ac_input | output | 1 | Input is AC coupled |
| rterm_en | output | 1 | Input termination enable |
| keep_cfg_pd | output | 1 | Keep configuration through power down |
| sda_timeout_en | output | 1 | Bus data-line timeout monitoring enable |
| loss_flag | output | 1 | Sticky loss event flag |
| wr_locked | output | 1 | Either write lock is set |

## Verification
The bench builds the block with its default parameters: vendor code 0xA, revision 0, device code 0xC9, byte-count reset 7 and amplitude reset 6. These defaults let the identity bytes and reset values be compared against fixed constants. The field-write table covers every mapped group, so the output ports can be checked against a value assembled across all three offsets of each 20-bit vector. The parameters leave the address map and lock behaviour unchanged, so the directed lock, loss-flag and reset sequences cover the full rule set.

// File: rtl/clkbuf_ctrl_regs.sv
module clkbuf_ctrl_regs #(
  parameter logic [3:0] VENDOR_CODE = 4'hA,
  parameter logic [3:0] REV_CODE    = 4'h0,
  parameter logic [7:0] DEVICE_CODE = 8'hC9,
  parameter logic [4:0] BC_INIT     = 5'd7,
  parameter logic [3:0] AMP_INIT    = 4'd6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  output logic [7:0]  rdata,
  input  logic        loss_in,
  input  logic [7:0]  oe_pin_stat,
  input  logic        sb_en_stat,
  input  logic [19:0] sb_state,
  output logic [19:0] out_en,
  output logic [19:0] sb_mask,
  output logic [19:0] slew_msb,
  output logic [19:0] slew_lsb,
  output logic [15:0] slew_opt,
  output logic [3:0]  amp_code,
  output logic [4:0]  blk_count,
  output logic        auto_dis_en,
  output logic        ac_input,
  output logic        rterm_en,
  output logic        keep_cfg_pd,
  output logic        sda_timeout_en,
  output logic        loss_flag,
  output logic        wr_locked
);
  localparam int NOUT = 20;
  localparam logic [7:0] A_EN_HI  = 8'h00, A_EN_LO  = 8'h01, A_EN_MID = 8'h02;
  localparam logic [7:0] A_OEPIN  = 8'h03, A_AOD    = 8'h04;
  localparam logic [7:0] A_ID0    = 8'h05, A_ID1    = 8'h06, A_BC     = 8'h07;
  localparam logic [7:0] A_MK_LO  = 8'h08, A_MK_MID = 8'h09, A_MK_HI  = 8'h0A;
  localparam logic [7:0] A_MS_LO  = 8'h0B, A_MS_MID = 8'h0C, A_MS_HI  = 8'h0D;
  localparam logic [7:0] A_AMP    = 8'h14, A_INCFG  = 8'h15;
  localparam logic [7:0] A_SB_LO  = 8'h21, A_SB_MID = 8'h22, A_SB_HI  = 8'h23;
  localparam logic [7:0] A_PLOCK  = 8'h26, A_LKST   = 8'h27;
  localparam logic [7:0] A_OPT12  = 8'h5B, A_OPT34  = 8'h5C;
  localparam logic [7:0] A_LS_LO  = 8'h62, A_LS_MID = 8'h63, A_LS_HI  = 8'h64;

  logic [NOUT-1:0] en_r, mask_r, msb_r, lsb_r;
  logic [15:0] opt_r;
  logic [3:0]  amp_r;
  logic [4:0]  bc_r;
  logic        aod_r, ac_r, rt_r, keep_r, sto_r;
  logic        perm_lock, clr_lock, flag_r;
  logic        wr_ok, wr_lockreg, mapped;

  assign wr_locked  = perm_lock | clr_lock;
  assign wr_ok      = wr_en & ~wr_locked;
  assign wr_lockreg = wr_en & (addr == A_LKST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r  <= '1;
      mask_r <= '0;
      msb_r <= '1;
      lsb_r <= '0;
      opt_r <= '0;
      amp_r <= AMP_INIT;
      bc_r  <= BC_INIT;
      aod_r <= 1'b1;
      ac_r  <= 1'b0;
      rt_r  <= 1'b0;
      keep_r <= 1'b1;
      sto_r <= 1'b1;
    end else if (wr_ok) begin
      case (addr)
        A_EN_LO:  en_r[7:0]    <= wdata;
        A_EN_MID: en_r[15:8]   <= wdata;
        A_EN_HI:  en_r[19:16]  <= wdata[6:3];
        A_MK_LO:  mask_r[7:0]  <= wdata;
        A_MK_MID: mask_r[15:8] <= wdata;
        A_MK_HI:  mask_r[19:16] <= wdata[3:0];
        A_MS_LO:  msb_r[7:0]   <= wdata;
        A_MS_MID: msb_r[15:8]  <= wdata;
        A_MS_HI:  msb_r[19:16] <= wdata[3:0];
        A_LS_LO:  lsb_r[7:0]   <= wdata;
        A_LS_MID: lsb_r[15:8]  <= wdata;
        A_LS_HI:  lsb_r[19:16] <= wdata[3:0];
        A_OPT12:  opt_r[7:0]   <= wdata;
        A_OPT34:  opt_r[15:8]  <= wdata;
        A_AMP:    amp_r        <= wdata[7:4];
        A_BC:     bc_r         <= wdata[4:0];
        A_AOD:    aod_r        <= wdata[4];
        A_INCFG: begin
          ac_r   <= wdata[7];
          rt_r   <= wdata[6];
          keep_r <= wdata[3];
          sto_r  <= wdata[2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_lock <= 1'b0;
      clr_lock  <= 1'b0;
      flag_r    <= 1'b0;
    end else begin
      if (wr_en && addr == A_PLOCK && wdata[0]) perm_lock <= 1'b1;
      if (wr_lockreg && wdata[0]) clr_lock <= ~clr_lock;
      if (loss_in) flag_r <= 1'b1;
      else if (wr_lockreg && wdata[1]) flag_r <= 1'b0;
    end
  end

  always_comb begin
    rdata  = '0;
    mapped = 1'b1;
    case (addr)
      A_EN_HI:  rdata = {1'b0, en_r[19:16], 3'b000};
      A_EN_LO:  rdata = en_r[7:0];
      A_EN_MID: rdata = en_r[15:8];
      A_OEPIN:  rdata = oe_pin_stat;
      A_AOD:    rdata = {3'b000, aod_r, 3'b000, sb_en_stat};
      A_ID0:    rdata = {REV_CODE, VENDOR_CODE};
      A_ID1:    rdata = DEVICE_CODE;
      A_BC:     rdata = {3'b000, bc_r};
      A_MK_LO:  rdata = mask_r[7:0];
      A_MK_MID: rdata = mask_r[15:8];
      A_MK_HI:  rdata = {4'h0, mask_r[19:16]};
      A_MS_LO:  rdata = msb_r[7:0];
      A_MS_MID: rdata = msb_r[15:8];
      A_MS_HI:  rdata = {4'h0, msb_r[19:16]};
      A_AMP:    rdata = {amp_r, 4'h0};
      A_INCFG:  rdata = {ac_r, rt_r, 2'b00, keep_r, sto_r, 1'b0, ~loss_in};
      A_SB_LO:  rdata = sb_state[7:0];
      A_SB_MID: rdata = sb_state[15:8];
      A_SB_HI:  rdata = {4'h0, sb_state[19:16]};
      A_PLOCK:  rdata = {7'd0, perm_lock};
      A_LKST:   rdata = {6'd0, flag_r, clr_lock};
      A_OPT12:  rdata = opt_r[7:0];
      A_OPT34:  rdata = opt_r[15:8];
      A_LS_LO:  rdata = lsb_r[7:0];
      A_LS_MID: rdata = lsb_r[15:8];
      A_LS_HI:  rdata = {4'h0, lsb_r[19:16]};
      default:  mapped = 1'b0;
    endcase
  end

  assign out_en         = en_r;
  assign sb_mask        = mask_r;
  assign slew_msb       = msb_r;
  assign slew_lsb       = lsb_r;
  assign slew_opt       = opt_r;
  assign amp_code       = amp_r;
  assign blk_count      = bc_r;
  assign auto_dis_en    = aod_r;
  assign ac_input       = ac_r;
  assign rterm_en       = rt_r;
  assign keep_cfg_pd    = keep_r;
  assign sda_timeout_en = sto_r;
  assign loss_flag      = flag_r;

  logic [127:0] ctrl_all;
  assign ctrl_all = {en_r, mask_r, msb_r, lsb_r, opt_r, amp_r, bc_r,
                     aod_r, ac_r, rt_r, keep_r, sto_r, 10'd0};

  p_perm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    perm_lock |=> perm_lock);
  p_lock_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_locked && addr != A_PLOCK && addr != A_LKST) |=> $stable(ctrl_all));
  p_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> $stable(ctrl_all));
  p_clr_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lockreg && wdata[0]) |=> (clr_lock != $past(clr_lock)));
  p_loss_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loss_in |=> loss_flag);
  p_loss_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lockreg && wdata[1] && !loss_in) |=> !loss_flag);
  p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MK_HI || addr == A_LS_HI || addr == A_SB_HI) |-> (rdata[7:4] == 4'h0));
  p_unmapped_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rdata == 8'h00));
endmodule

// File: tb/clkbuf_ctrl_regs_tb.sv
module clkbuf_ctrl_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr_en = 1'b0, loss_in = 1'b0, sb_en_stat = 1'b0;
  logic [7:0] oe_pin_stat = '0;
  logic [19:0] sb_state = '0;
  logic [7:0] rdata;
  logic [19:0] out_en, sb_mask, slew_msb, slew_lsb;
  logic [15:0] slew_opt;
  logic [3:0] amp_code;
  logic [4:0] blk_count;
  logic auto_dis_en, ac_input, rterm_en, keep_cfg_pd, sda_timeout_en, loss_flag, wr_locked;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  clkbuf_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata),
    .loss_in(loss_in), .oe_pin_stat(oe_pin_stat), .sb_en_stat(sb_en_stat), .sb_state(sb_state),
    .out_en(out_en), .sb_mask(sb_mask), .slew_msb(slew_msb), .slew_lsb(slew_lsb),
    .slew_opt(slew_opt), .amp_code(amp_code), .blk_count(blk_count), .auto_dis_en(auto_dis_en),
    .ac_input(ac_input), .rterm_en(rterm_en), .keep_cfg_pd(keep_cfg_pd),
    .sda_timeout_en(sda_timeout_en), .loss_flag(loss_flag), .wr_locked(wr_locked));

  // {offset, write byte, expected read}; rows for 0x00, 0x0A, 0x0D, 0x64, 0x14, 0x07, 0x04, 0x15 also cover R4
  localparam logic [23:0] VEC [16] = '{
    24'h01_5A_5A, 24'h02_C3_C3, 24'h00_FF_78, 24'h08_A5_A5,
    24'h09_3C_3C, 24'h0A_FF_0F, 24'h0B_00_00, 24'h0D_FF_0F,
    24'h62_81_81, 24'h64_FF_0F, 24'h5B_21_21, 24'h5C_F3_F3,
    24'h14_FF_F0, 24'h07_FF_1F, 24'h04_FF_10, 24'h15_FF_CD};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #2;
    chk(tag, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_en", {12'd0, out_en}, 32'hFFFFF);
    chk("R1 slew_msb", {12'd0, slew_msb}, 32'hFFFFF);
    chk("R1 masks", {12'd0, sb_mask}, 32'h0);
    rdchk("R1 0x00", 8'h00, 8'h78);
    rdchk("R1 0x62", 8'h62, 8'h00);
    rdchk("R1 0x14", 8'h14, 8'h60);
    rdchk("R1 0x07", 8'h07, 8'h07);
    rdchk("R1 0x15", 8'h15, 8'h0D);
    rdchk("R1 0x04", 8'h04, 8'h10);
    rdchk("R1 0x5C", 8'h5C, 8'h00);
    rdchk("R1 0x27", 8'h27, 8'h00);
    rdchk("R1 0x26", 8'h26, 8'h00);
    // R2 identity
    rdchk("R2 0x05", 8'h05, 8'h0A);
    wr(8'h06, 8'h00);
    rdchk("R2 0x06", 8'h06, 8'hC9);
    // R3 table walk
    for (int i = 0; i < 16; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rdchk("R3 R4 table", VEC[i][23:16], VEC[i][7:0]);
    end
    chk("R3 out_en", {12'd0, out_en}, 32'hFC35A);
    chk("R3 sb_mask", {12'd0, sb_mask}, 32'hF3CA5);
    chk("R3 slew_msb", {12'd0, slew_msb}, 32'hFFF00);
    chk("R3 slew_lsb", {12'd0, slew_lsb}, 32'hF0081);
    chk("R3 slew_opt", {16'd0, slew_opt}, 32'hF321);
    chk("R3 amp/bc", {23'd0, amp_code, blk_count}, {23'd0, 4'hF, 5'h1F});
    chk("R3 cfg bits", {27'd0, auto_dis_en, ac_input, rterm_en, keep_cfg_pd, sda_timeout_en}, 32'h1F);
    // R5 unmapped
    wr(8'h0E, 8'hFF);
    wr(8'h20, 8'h00);
    wr(8'h65, 8'h00);
    rdchk("R5 read 0x0E", 8'h0E, 8'h00);
    rdchk("R5 read 0xFF", 8'hFF, 8'h00);
    chk("R5 state kept", {12'd0, out_en}, 32'hFC35A);
    chk("R5 masks kept", {12'd0, sb_mask}, 32'hF3CA5);
    // R11 read-before-update
    @(negedge clk);
    addr = 8'h02; wdata = 8'h55; wr_en = 1'b1;
    #2 chk("R11 old value during write", {24'd0, rdata}, 32'hC3);
    @(negedge clk);
    wr_en = 1'b0;
    #2 chk("R11 new value after edge", {24'd0, rdata}, 32'h55);
    // R10 status readbacks
    oe_pin_stat = 8'h96; sb_state = 20'hABCDE; sb_en_stat = 1'b1;
    rdchk("R10 0x03", 8'h03, 8'h96);
    rdchk("R10 0x21", 8'h21, 8'hDE);
    rdchk("R10 0x22", 8'h22, 8'hBC);
    rdchk("R10 0x23", 8'h23, 8'h0A);
    rdchk("R10 0x04", 8'h04, 8'h11);
    // R9 loss flag
    @(negedge clk);
    loss_in = 1'b1;
    rdchk("R10 0x15 under loss", 8'h15, 8'hCC);
    @(negedge clk);
    loss_in = 1'b0;
    rdchk("R9 flag set", 8'h27, 8'h02);
    repeat (5) @(negedge clk);
    rdchk("R9 flag held", 8'h27, 8'h02);
    wr(8'h27, 8'h02);
    rdchk("R9 flag cleared", 8'h27, 8'h00);
    @(negedge clk);
    loss_in = 1'b1; addr = 8'h27; wdata = 8'h02; wr_en = 1'b1;
    @(negedge clk);
    loss_in = 1'b0; wr_en = 1'b0;
    rdchk("R9 clear vs event", 8'h27, 8'h02);
    wr(8'h27, 8'h02);
    // R7 clearable lock
    wr(8'h27, 8'h01);
    rdchk("R7 lock set", 8'h27, 8'h01);
    chk("R8 locked out", {31'd0, wr_locked}, 32'h1);
    wr(8'h01, 8'h00);
    rdchk("R8 write blocked", 8'h01, 8'h5A);
    wr(8'h27, 8'h00);
    rdchk("R7 write 0 no effect", 8'h27, 8'h01);
    wr(8'h27, 8'h01);
    rdchk("R7 lock released", 8'h27, 8'h00);
    wr(8'h01, 8'h11);
    rdchk("R7 write after release", 8'h01, 8'h11);
    // R6 permanent lock
    wr(8'h26, 8'h01);
    rdchk("R6 lock set", 8'h26, 8'h01);
    wr(8'h14, 8'h30);
    rdchk("R8 amp blocked", 8'h14, 8'hF0);
    wr(8'h27, 8'h01);
    rdchk("R8 lock reg writable", 8'h27, 8'h01);
    wr(8'h27, 8'h01);
    wr(8'h01, 8'h22);
    rdchk("R8 still locked", 8'h01, 8'h11);
    wr(8'h26, 8'h00);
    rdchk("R6 write 0 no effect", 8'h26, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rdchk("R6 reset releases", 8'h26, 8'h00);
    rdchk("R1 after reset", 8'h01, 8'hFF);
    summary();
  end
endmodule